// File: doc/BRIEF.md
# Translation Control Register and First-Level Walk Gate

This block holds the control word that governs short-descriptor address translation, together with the two translation-table base registers. A register write port loads any of the three, and the control word is cleaned on the way in: which bits survive depends on three build-time options. These options are extended-address support, secure-state support and the newer architecture revision. A combinational read port returns the stored values.

For every lookup the block takes a 32-bit virtual address and picks one of the two base registers. It picks the upper-region base when the address has any bit set in a high-order window whose width is the split field of the control word, and the lower-region base otherwise. It then forms the physical address of the first-level descriptor. Each base register has its own walk-disable bit in the control word. When the chosen base has its disable bit set, no address is formed and the response reports a section translation fault instead.

The lookup side uses a valid/ready request and a valid/ready response. The result appears one cycle after the request is accepted and is held until it is taken.

Top module: `xlat_ctl_gate`

## Requirements
- R1: After reset the control word and both base registers read as zero, no response is valid and a request can be accepted.
- R2: With the newer revision off, extended-address support on and bit 31 of the written control value set, bits [21:19], [15:14] and [6:3] are stored as zero and every other bit is stored as written.
- R3: With the newer revision off and R2 not applying, a control write keeps bits [2:0] (split field N) and, when secure-state support is built in, also bit 4 (lower walk-disable) and bit 5 (upper walk-disable); every other bit is stored as zero.
- R4: With the newer revision on, the control word is stored exactly as written.
- R5: Select code 1 addresses the lower base register and select code 2 the upper base register; both are stored and read back unaltered. Code 0 addresses the control word and code 3 reads as zero.
- R6: A lookup uses the upper base exactly when the virtual address shifted right by (32 - N) is non-zero. When N is 0 the upper base is never used.
- R7: When the chosen base has its walk-disable bit set (bit 5 for upper, bit 4 for lower), the response has fault set to 1, code 5 and address zero. Otherwise fault is 0 and code is 0.
- R8: A non-faulting response carries a table base ORed with virtual address bits [31:20] placed at bits [13:2]. The table base is the upper base with bits [13:0] cleared, or the lower base with bits [13-N:0] cleared.
- R9: The response is valid on the cycle after the request is accepted. While it is valid and not taken, it holds its contents and the request side is not ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 lower base, 2 upper base |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Read target, same coding; 3 reads zero |
| rd_data | output | 32 | Read value |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_va | input | 32 | Virtual address of the lookup |
| resp_valid | output | 1 | Lookup result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_fault | output | 1 | Walk disabled for the chosen base |
| resp_code | output | 4 | Fault code, 5 on a section translation fault, else 0 |
| resp_addr | output | 32 | First-level descriptor address, zero on a fault |

## Verification
The derived window and alignment masks are the state most likely to go wrong unseen. A stale or miscomputed mask shows up on the first lookup after a control write. It appears as the wrong base being used or as low base bits leaking into the descriptor address, so the bench sweeps every split value with addresses on both sides of the window edge. A wrongly cleaned control word shows on the read port on the cycle after the write. A walk-disable bit wired to the wrong base shows as a fault or non-fault on the opposite region. Because each build option is a separate variant, the bench instantiates four of them side by side.

// File: rtl/xlat_ctl_pkg.sv
// Shared constants and mask helpers for the translation control block.
// Assumes a 32-bit word and a 16 KiB aligned upper translation table.
package xlat_ctl_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned SEL_W     = 2;
    localparam int unsigned SPLIT_W   = 3;
    localparam int unsigned CODE_W    = 4;
    localparam int unsigned TBL_LOW   = 14;   // alignment bits of a full table
    localparam int unsigned IDX_SHIFT = 18;   // VA[31:20] lands at [13:2]

    localparam int unsigned PDIS_LO_BIT = 4;
    localparam int unsigned PDIS_HI_BIT = 5;
    localparam int unsigned EXT_BIT     = 31;

    localparam logic [SEL_W-1:0] SEL_CTL   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_BASE0 = 2'd1;
    localparam logic [SEL_W-1:0] SEL_BASE1 = 2'd2;

    localparam logic [CODE_W-1:0] CODE_SECT_FAULT = 4'd5;

    localparam logic [WORD_W-1:0] LOW_ONES  = WORD_W'((1 << TBL_LOW) - 1);
    localparam logic [WORD_W-1:0] IDX_MASK  = LOW_ONES & ~WORD_W'(3);
    // kept bits on the extended path: clear [21:19], [15:14], [6:3]
    localparam logic [WORD_W-1:0] EXT_KEEP  = ~(WORD_W'(32'h0038_C078));
    localparam logic [WORD_W-1:0] SPLIT_KEEP = WORD_W'((1 << SPLIT_W) - 1);
    localparam logic [WORD_W-1:0] SEC_KEEP  = SPLIT_KEEP
                                            | (WORD_W'(1) << PDIS_LO_BIT)
                                            | (WORD_W'(1) << PDIS_HI_BIT);

    // high-order window that steers a lookup to the upper base
    function automatic logic [WORD_W-1:0] hi_window(input logic [SPLIT_W-1:0] n);
        return ~({WORD_W{1'b1}} >> n);
    endfunction

    // alignment mask applied to the lower base
    function automatic logic [WORD_W-1:0] lo_align(input logic [SPLIT_W-1:0] n);
        return ~(LOW_ONES >> n);
    endfunction

endpackage

// File: rtl/xlat_ctl_wrmask.sv
// Control-word write cleaner. Purely combinational: the build options
// choose a keep mask, and the extended path is picked at run time from
// bit 31 of the incoming value. Assumes options are fixed per instance.
module xlat_ctl_wrmask
    import xlat_ctl_pkg::*;
#(
    parameter bit LONG_ADDR_EN = 1'b1,
    parameter bit SECURE_EN    = 1'b1,
    parameter bit V8_MODE      = 1'b0
) (
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] clean
);

    localparam logic [WORD_W-1:0] SHORT_KEEP = SECURE_EN ? SEC_KEEP : SPLIT_KEEP;

    logic [WORD_W-1:0] keep;

    generate
        if (V8_MODE) begin : g_v8
            assign keep = {WORD_W{1'b1}};
        end else if (LONG_ADDR_EN) begin : g_ext
            assign keep = raw[EXT_BIT] ? EXT_KEEP : SHORT_KEEP;
        end else begin : g_short
            assign keep = SHORT_KEEP;
        end
    endgenerate

    // apply the selected keep mask
    always_comb clean = raw & keep;

endmodule

// File: rtl/xlat_ctl_regs.sv
// Register file: control word, two base registers and the two masks
// derived from the split field. Masks are refreshed on every control
// write so lookups never recompute them. Reads are combinational.
module xlat_ctl_regs
    import xlat_ctl_pkg::*;
#(
    parameter bit LONG_ADDR_EN = 1'b1,
    parameter bit SECURE_EN    = 1'b1,
    parameter bit V8_MODE      = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [WORD_W-1:0]   rd_data,
    output logic [SPLIT_W-1:0]  split_n,
    output logic                pdis_lo,
    output logic                pdis_hi,
    output logic [WORD_W-1:0]   base0_q,
    output logic [WORD_W-1:0]   base1_q,
    output logic [WORD_W-1:0]   win_q,
    output logic [WORD_W-1:0]   align_q
);

    logic [WORD_W-1:0] ctl_q;
    logic [WORD_W-1:0] ctl_clean;

    xlat_ctl_wrmask #(
        .LONG_ADDR_EN (LONG_ADDR_EN),
        .SECURE_EN    (SECURE_EN),
        .V8_MODE      (V8_MODE)
    ) u_wrmask (
        .raw   (wr_data),
        .clean (ctl_clean)
    );

    // store writes and refresh the derived masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            base0_q <= '0;
            base1_q <= '0;
            win_q   <= hi_window('0);
            align_q <= lo_align('0);
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTL: begin
                    ctl_q   <= ctl_clean;
                    win_q   <= hi_window(ctl_clean[SPLIT_W-1:0]);
                    align_q <= lo_align(ctl_clean[SPLIT_W-1:0]);
                end
                SEL_BASE0: base0_q <= wr_data;
                SEL_BASE1: base1_q <= wr_data;
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        case (rd_sel)
            SEL_CTL:   rd_data = ctl_q;
            SEL_BASE0: rd_data = base0_q;
            SEL_BASE1: rd_data = base1_q;
            default:   rd_data = '0;
        endcase
    end

    // expose the fields the lookup path needs
    always_comb begin
        split_n = ctl_q[SPLIT_W-1:0];
        pdis_lo = ctl_q[PDIS_LO_BIT];
        pdis_hi = ctl_q[PDIS_HI_BIT];
    end

    generate
        if (V8_MODE) begin : g_chk_v8
            // R4: raw store
            p_raw_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel == SEL_CTL) |=> (ctl_q == $past(wr_data)));
        end else begin : g_chk_pre
            // R3: short path leaves only split and walk-disable bits
            p_short_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !ctl_q[EXT_BIT] |-> (ctl_q[30:6] == '0 && !ctl_q[3]));
            // R2: extended path clears its reserved fields
            p_ext_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ctl_q[EXT_BIT] |-> (ctl_q[21:19] == '0 && ctl_q[15:14] == '0
                                    && ctl_q[6:3] == '0));
        end
    endgenerate

endmodule

// File: rtl/xlat_l1_gate.sv
// Lookup path: steers a virtual address to one base register, gates the
// walk by that base's disable bit, and registers the first-level
// descriptor address or a section fault. One response slot with hold.
module xlat_l1_gate
    import xlat_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [WORD_W-1:0]   req_va,
    output logic                resp_valid,
    input  logic                resp_ready,
    output logic                resp_fault,
    output logic [CODE_W-1:0]   resp_code,
    output logic [WORD_W-1:0]   resp_addr,
    input  logic [SPLIT_W-1:0]  split_n,
    input  logic                pdis_lo,
    input  logic                pdis_hi,
    input  logic [WORD_W-1:0]   base0_q,
    input  logic [WORD_W-1:0]   base1_q,
    input  logic [WORD_W-1:0]   win_q,
    input  logic [WORD_W-1:0]   align_q
);

    logic              accept;
    logic              use_hi;
    logic              blocked;
    logic [WORD_W-1:0] tbl_base;
    logic [WORD_W-1:0] desc_addr;

    // free slot or slot being drained
    always_comb req_ready = !resp_valid || resp_ready;
    always_comb accept    = req_valid && req_ready;

    // base selection, walk gate and address formation
    always_comb begin
        use_hi    = |(req_va & win_q);
        blocked   = use_hi ? pdis_hi : pdis_lo;
        tbl_base  = use_hi ? (base1_q & ~LOW_ONES) : (base0_q & align_q);
        desc_addr = tbl_base | ((req_va >> IDX_SHIFT) & IDX_MASK);
    end

    // response slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_code  <= '0;
            resp_addr  <= '0;
        end else if (accept) begin
            resp_valid <= 1'b1;
            resp_fault <= blocked;
            resp_code  <= blocked ? CODE_SECT_FAULT : '0;
            resp_addr  <= blocked ? '0 : desc_addr;
        end else if (resp_ready) begin
            resp_valid <= 1'b0;
        end
    end

    // R6: an empty split never steers to the upper base
    p_no_hi_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && split_n == '0) |-> !use_hi);
    // R7: a fault carries code 5 and no address
    p_fault_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_code == CODE_SECT_FAULT && resp_addr == '0));
    // R8: descriptor addresses are word aligned
    p_addr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_addr[1:0] == 2'b00));
    // R9: accepted request yields a response next cycle
    p_resp_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> resp_valid);
    // R9: held response is stable
    p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_addr)
                                         && $stable(resp_fault) && $stable(resp_code)));

endmodule

// File: rtl/xlat_ctl_gate.sv
// Top: translation control and base registers plus the gated
// first-level descriptor address generator. Build options fix the
// write-cleaning rules; reset is synchronous and active low.
module xlat_ctl_gate
    import xlat_ctl_pkg::*;
#(
    parameter bit LONG_ADDR_EN = 1'b1,
    parameter bit SECURE_EN    = 1'b1,
    parameter bit V8_MODE      = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [WORD_W-1:0]   req_va,
    output logic                resp_valid,
    input  logic                resp_ready,
    output logic                resp_fault,
    output logic [CODE_W-1:0]   resp_code,
    output logic [WORD_W-1:0]   resp_addr
);

    logic [SPLIT_W-1:0] split_n;
    logic               pdis_lo;
    logic               pdis_hi;
    logic [WORD_W-1:0]  base0_q;
    logic [WORD_W-1:0]  base1_q;
    logic [WORD_W-1:0]  win_q;
    logic [WORD_W-1:0]  align_q;

    xlat_ctl_regs #(
        .LONG_ADDR_EN (LONG_ADDR_EN),
        .SECURE_EN    (SECURE_EN),
        .V8_MODE      (V8_MODE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .split_n (split_n),
        .pdis_lo (pdis_lo),
        .pdis_hi (pdis_hi),
        .base0_q (base0_q),
        .base1_q (base1_q),
        .win_q   (win_q),
        .align_q (align_q)
    );

    xlat_l1_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_va     (req_va),
        .resp_valid (resp_valid),
        .resp_ready (resp_ready),
        .resp_fault (resp_fault),
        .resp_code  (resp_code),
        .resp_addr  (resp_addr),
        .split_n    (split_n),
        .pdis_lo    (pdis_lo),
        .pdis_hi    (pdis_hi),
        .base0_q    (base0_q),
        .base1_q    (base1_q),
        .win_q      (win_q),
        .align_q    (align_q)
    );

endmodule

// File: tb/xlat_ctl_gate_test.sv
`timescale 1ns/1ps
module xlat_ctl_gate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        resp_ready = 1'b1;

    logic [31:0] rd_a, rd_b, rd_c, rd_d;
    logic        req_ready, resp_valid, resp_fault;
    logic [3:0]  resp_code;
    logic [31:0] resp_addr;

    // unused lookup outputs of the side variants
    logic        x_rr [3];
    logic        x_rv [3];
    logic        x_rf [3];
    logic [3:0]  x_rc [3];
    logic [31:0] x_ra [3];

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;   // 250 MHz

    // default build: extended addresses and secure state, older revision
    xlat_ctl_gate uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_a), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_fault(resp_fault), .resp_code(resp_code), .resp_addr(resp_addr));

    xlat_ctl_gate #(.LONG_ADDR_EN(1'b1), .SECURE_EN(1'b1), .V8_MODE(1'b1)) uut_v8 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_b), .req_valid(1'b0), .req_ready(x_rr[0]),
        .req_va(32'h0), .resp_valid(x_rv[0]), .resp_ready(1'b1),
        .resp_fault(x_rf[0]), .resp_code(x_rc[0]), .resp_addr(x_ra[0]));

    xlat_ctl_gate #(.LONG_ADDR_EN(1'b0), .SECURE_EN(1'b0), .V8_MODE(1'b0)) uut_plain (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_c), .req_valid(1'b0), .req_ready(x_rr[1]),
        .req_va(32'h0), .resp_valid(x_rv[1]), .resp_ready(1'b1),
        .resp_fault(x_rf[1]), .resp_code(x_rc[1]), .resp_addr(x_ra[1]));

    xlat_ctl_gate #(.LONG_ADDR_EN(1'b0), .SECURE_EN(1'b1), .V8_MODE(1'b0)) uut_sec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_d), .req_valid(1'b0), .req_ready(x_rr[2]),
        .req_va(32'h0), .resp_valid(x_rv[2]), .resp_ready(1'b1),
        .resp_fault(x_rf[2]), .resp_code(x_rc[2]), .resp_addr(x_ra[2]));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected stored control word for one build
    function automatic logic [31:0] exp_ctl(input logic [31:0] v, input bit lng,
                                            input bit sec, input bit v8);
        logic [31:0] r;
        if (v8) return v;
        if (lng && v[31]) begin
            r = v;
            r[21:19] = '0;
            r[15:14] = '0;
            r[6:3]   = '0;
            return r;
        end
        r = '0;
        r[2:0] = v[2:0];
        if (sec) r[5:4] = v[5:4];
        return r;
    endfunction

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one lookup with the consumer always ready; sample one cycle later
    task automatic lookup(input logic [31:0] va, input logic [2:0] n, input logic pd0,
                          input logic pd1, input logic [31:0] b0, input logic [31:0] b1);
        logic        hi, flt;
        logic [31:0] base, addr;
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        hi   = (n != 0) && ((va >> (32 - n)) != 0);
        flt  = hi ? pd1 : pd0;
        base = hi ? {b1[31:14], 14'b0} : (b0 & (32'hFFFF_FFFF << (14 - n)));
        addr = flt ? 32'h0 : (base | {18'b0, va[31:20], 2'b00});
        check(hi ? "R6/R7/R8 upper" : "R6/R7/R8 lower",
              {27'b0, resp_valid, resp_fault, resp_code, resp_addr},
              {27'b0, 1'b1, flt, (flt ? 4'd5 : 4'd0), addr});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        logic [31:0] b0, b1;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 3; s++) begin
            rd_sel = 2'(s);
            #0.1;
            check("R1 reset readback", {32'b0, rd_a}, 64'h0);
        end
        check("R1 idle handshake", {62'b0, resp_valid, req_ready}, 64'h1);

        // R2 R3 R4: write cleaning on four builds
        lf = 32'hACE1_1234;
        for (int i = 0; i < 48; i++) begin
            logic [31:0] v;
            if (i == 0) v = 32'hFFFF_FFFF;
            else if (i == 1) v = 32'h7FFF_FFFF;
            else if (i == 2) v = 32'h8000_0000;
            else begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                v = lf;
            end
            write_reg(2'd0, v);
            rd_sel = 2'd0;
            #0.1;
            check(v[31] ? "R2 extended clean" : "R3 short clean secure",
                  {32'b0, rd_a}, {32'b0, exp_ctl(v, 1, 1, 0)});
            check("R4 raw store", {32'b0, rd_b}, {32'b0, exp_ctl(v, 1, 1, 1)});
            check("R3 short clean plain", {32'b0, rd_c}, {32'b0, exp_ctl(v, 0, 0, 0)});
            check("R3 short clean no-ext secure", {32'b0, rd_d}, {32'b0, exp_ctl(v, 0, 1, 0)});
        end

        // R5: base registers and unused select
        b0 = 32'hA5A5_5A5A;
        b1 = 32'h5A5A_A5A5;
        write_reg(2'd1, b0);
        write_reg(2'd2, b1);
        rd_sel = 2'd1; #0.1;
        check("R5 lower base", {32'b0, rd_a}, {32'b0, b0});
        rd_sel = 2'd2; #0.1;
        check("R5 upper base", {32'b0, rd_a}, {32'b0, b1});
        rd_sel = 2'd3; #0.1;
        check("R5 unused select", {32'b0, rd_a}, 64'h0);

        // R6 R7 R8: sweep split and walk-disable bits over edge addresses
        for (int n = 0; n < 8; n++) begin
            for (int pd = 0; pd < 4; pd++) begin
                logic [31:0] edge_hi;
                write_reg(2'd0, {26'b0, pd[1], pd[0], 1'b0, 3'(n)});
                edge_hi = 32'((64'h1 << (32 - n)));
                lookup(32'h0,             3'(n), pd[0], pd[1], b0, b1);
                lookup(32'hFFFF_FFFF,     3'(n), pd[0], pd[1], b0, b1);
                lookup(edge_hi,           3'(n), pd[0], pd[1], b0, b1);
                lookup(edge_hi - 32'h1,   3'(n), pd[0], pd[1], b0, b1);
                lookup(32'h8000_0000,     3'(n), pd[0], pd[1], b0, b1);
                lookup(32'h0012_3456,     3'(n), pd[0], pd[1], b0, b1);
                lookup(32'h1FFF_FFFF,     3'(n), pd[0], pd[1], b0, b1);
                for (int k = 0; k < 4; k++) begin
                    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                    lookup(lf, 3'(n), pd[0], pd[1], b0, b1);
                end
            end
        end

        // R9: latency and hold under back-pressure
        write_reg(2'd0, 32'h0000_0002);
        @(negedge clk);
        resp_ready = 1'b0;
        req_valid = 1'b1; req_va = 32'h4030_0000;
        check("R9 no response before accept", {63'b0, resp_valid}, 64'h0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 response after one cycle", {63'b0, resp_valid}, 64'h1);
        held = resp_addr;
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            check("R9 held response", {30'b0, resp_valid, req_ready, resp_addr},
                  {30'b0, 1'b1, 1'b0, held});
        end
        resp_ready = 1'b1;
        @(negedge clk);
        check("R9 drained", {62'b0, resp_valid, req_ready}, 64'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule